// File: doc/BRIEF.md
# PCI Initiator Termination Monitor

This block observes a single PCI bus from the initiator's viewpoint and drives no bus signal itself. It samples the active-low framing, ready, claim, stop and 64-bit request and acknowledge lines on every rising clock edge. From these samples it works out how each transaction ends. When the bus goes idle again it gives one outcome code, the number of completed data phases, and whether the transfer ran 64 bits wide. Two sticky flags report handshake violations.

The results change only at a completion pulse. Between pulses they stay stable, so a slower consumer can read them at any time. The block has no data stream, so no valid/ready handshake and no back-pressure apply. Every pin is a plain control or status signal.

Top module: `pci_term_monitor`

## Requirements
- R1: A synchronous active-low reset clears the following: `done`, `outcome` (code 0, none), `xfer_count`, `wide64`, `viol_ack64` and `viol_ready`.
- R2: A transaction starts at the first edge that samples FRAME# low.
- R2 (continued): After the transaction ends, `done` is high for exactly one cycle. That cycle follows the first edge that samples FRAME# and IRDY# both high.
- R2 (continued): `outcome`, `xfer_count` and `wide64` keep their values until the next `done`.
- R3: Number the start edge 0. If DEVSEL# is sampled high at every edge from 1 through DEVSEL_WIN (default 5), the outcome is master abort, code 6. DEVSEL# first sampled low at edge DEVSEL_WIN still counts as a claim.
- R4: A data phase completes at an edge where IRDY# is low and TRDY# or STOP# is also low. A phase with IRDY# and TRDY# both low moves data and increments `xfer_count`. A data-moving phase sampled with FRAME# high and STOP# high ends the transaction with normal completion, code 1.
- R5: An edge with STOP#, TRDY#, DEVSEL# and IRDY# all low is a disconnect with data, code 2. That phase is counted in `xfer_count`.
- R6: An edge with STOP#, DEVSEL# and IRDY# low, TRDY# high, and no data phase moved yet is a retry, code 4. `xfer_count` is then 0.
- R7: The same condition as R6, after one or more data phases have moved data, is a disconnect without data, code 3.
- R8: An edge with STOP# low and DEVSEL# high, while the transaction is open, is a target abort, code 5.
- R9: `wide64` is 1 only in two cases together. REQ64# was low at the start edge, and ACK64# was sampled low at some later edge of the same transaction.
- R10: `viol_ack64` sets and stays set in two cases. ACK64# is low at an idle edge where REQ64# is high. Or ACK64# is low during a transaction whose start edge sampled REQ64# high.
- R11: `viol_ready` sets and stays set in two cases. IRDY# rises after being low in a phase that had not completed. Or TRDY# rises after being low while IRDY# was high. The check does not apply after a master abort has been decided.
- R12: A new transaction may begin in the same cycle that `done` of the previous one is high. It is classified independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| stop_n | input | 1 | STOP#, active low |
| req64_n | input | 1 | REQ64#, active low |
| ack64_n | input | 1 | ACK64#, active low |
| done | output | 1 | One-cycle pulse after the bus returns to idle |
| outcome | output | 3 | Termination code (0 none, 1 normal, 2 disconnect with data, 3 disconnect without data, 4 retry, 5 target abort, 6 master abort) |
| xfer_count | output | CNT_W | Completed data-moving phases of the last transaction |
| wide64 | output | 1 | Last transaction ran 64 bits wide |
| viol_ack64 | output | 1 | Sticky: ACK64# without REQ64# |
| viol_ready | output | 1 | Sticky: IRDY# or TRDY# withdrawn before phase completion |

## Verification
The bench targets the five-edge claim window at its edge. It uses a claim at the last allowed edge and a transaction with no claim at all. A design off by one would report master abort for the late claim, or would miss the abort.

It sends stop terminations before and after the first data phase. A design that did not track phase position would mix up retry and disconnect without data. A design that left the final phase uncounted would give a wrong count for disconnect with data.

It also sends an acknowledge without a request, and ready lines that are withdrawn early. Stuck or self-clearing flags show up as wrong sticky outputs. The bench checks that the legal release of IRDY# after a master abort does not raise a false violation.

// File: rtl/pci_term_pkg.sv
package pci_term_pkg;

  typedef enum logic [2:0] {
    OC_NONE        = 3'd0,
    OC_NORMAL      = 3'd1,
    OC_DISC_DATA   = 3'd2,
    OC_DISC_NODATA = 3'd3,
    OC_RETRY       = 3'd4,
    OC_TGT_ABORT   = 3'd5,
    OC_MST_ABORT   = 3'd6
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_DRAIN = 2'd2
  } mon_state_e;

  // Bus sample with every field active high (1 = asserted on the wire).
  typedef struct packed {
    logic frame;
    logic irdy;
    logic trdy;
    logic devsel;
    logic stop;
    logic req64;
    logic ack64;
  } bus_smp_t;

endpackage

// File: rtl/pci_term_classifier.sv
module pci_term_classifier
  import pci_term_pkg::*;
#(
  parameter int DEVSEL_WIN = 5,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bus_smp_t         smp,
  output mon_state_e       state_o,
  output outcome_e         term_o,
  output logic             done_o,
  output logic [2:0]       outcome_o,
  output logic [CNT_W-1:0] xfer_count_o,
  output logic             wide64_o
);

  localparam int WIN_W = $clog2(DEVSEL_WIN + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(DEVSEL_WIN);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  mon_state_e       state_q;
  outcome_e         term_q;
  outcome_e         out_q;
  logic [WIN_W-1:0] wait_q;
  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] cnt_out_q;
  logic             dev_seen_q;
  logic             req_start_q;
  logic             ack_seen_q;
  logic             wide_q;
  logic             done_q;

  logic [WIN_W-1:0] since_start;
  logic [CNT_W-1:0] phase_inc;
  logic             moves_data;
  logic             bus_idle;

  always_comb begin
    since_start = wait_q + 1'b1;
    moves_data  = smp.irdy && smp.trdy;
    phase_inc   = (phase_q == CNT_MAX) ? CNT_MAX : phase_q + 1'b1;
    bus_idle    = !smp.frame && !smp.irdy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      term_q      <= OC_NONE;
      out_q       <= OC_NONE;
      wait_q      <= '0;
      phase_q     <= '0;
      cnt_out_q   <= '0;
      dev_seen_q  <= 1'b0;
      req_start_q <= 1'b0;
      ack_seen_q  <= 1'b0;
      wide_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (smp.frame) begin
            state_q     <= ST_BUSY;
            wait_q      <= '0;
            phase_q     <= '0;
            dev_seen_q  <= 1'b0;
            req_start_q <= smp.req64;
            ack_seen_q  <= 1'b0;
            term_q      <= OC_NONE;
          end
        end
        ST_BUSY: begin
          if (wait_q != WIN_LAST) wait_q <= since_start;
          if (smp.devsel) dev_seen_q <= 1'b1;
          if (smp.ack64)  ack_seen_q <= 1'b1;
          if (!dev_seen_q && !smp.devsel && since_start == WIN_LAST) begin
            term_q  <= OC_MST_ABORT;
            state_q <= ST_DRAIN;
          end else if (smp.stop && !smp.devsel) begin
            term_q  <= OC_TGT_ABORT;
            state_q <= ST_DRAIN;
          end else if (smp.stop && smp.irdy) begin
            state_q <= ST_DRAIN;
            if (smp.trdy) begin
              term_q  <= OC_DISC_DATA;
              phase_q <= phase_inc;
            end else if (phase_q == '0) begin
              term_q <= OC_RETRY;
            end else begin
              term_q <= OC_DISC_NODATA;
            end
          end else if (moves_data) begin
            phase_q <= phase_inc;
            if (!smp.frame) begin
              term_q  <= OC_NORMAL;
              state_q <= ST_DRAIN;
            end
          end else if (bus_idle) begin
            term_q  <= (dev_seen_q || smp.devsel) ? OC_NORMAL : OC_MST_ABORT;
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (smp.ack64) ack_seen_q <= 1'b1;
          if (bus_idle) begin
            done_q    <= 1'b1;
            out_q     <= term_q;
            cnt_out_q <= phase_q;
            wide_q    <= req_start_q && ack_seen_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o      = state_q;
  assign term_o       = term_q;
  assign done_o       = done_q;
  assign outcome_o    = out_q;
  assign xfer_count_o = cnt_out_q;
  assign wide64_o     = wide_q;

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2: pulse only follows an idle bus sample
  a_r2_done_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(!smp.frame && !smp.irdy));

  // R3: an unclaimed open transaction never outlives the claim window
  a_r3_claim_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY && !dev_seen_q) |-> (wait_q < WIN_LAST));

  // R6: retry reports no moved data
  a_r6_retry_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && out_q == OC_RETRY) |-> (cnt_out_q == '0));

  // R9: an unclaimed transaction is never reported wide
  a_r9_abort_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && out_q == OC_MST_ABORT) |-> !wide_q);

endmodule

// File: rtl/pci_term_hs_check.sv
module pci_term_hs_check
  import pci_term_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_smp_t   smp,
  input  mon_state_e state,
  input  outcome_e   term,
  output logic       viol_ack64_o,
  output logic       viol_ready_o
);

  logic p_irdy_q, p_trdy_q, p_stop_q;
  logic req_lat_q;
  logic ack_bad, rdy_bad, irdy_drop, trdy_drop, check_on;

  always_comb begin
    ack_bad   = smp.ack64 && ((state == ST_IDLE) ? !smp.req64 : !req_lat_q);
    irdy_drop = p_irdy_q && !(p_trdy_q || p_stop_q) && !smp.irdy;
    trdy_drop = p_trdy_q && !p_irdy_q && !smp.trdy;
    check_on  = (state != ST_IDLE) && (term != OC_MST_ABORT);
    rdy_bad   = check_on && (irdy_drop || trdy_drop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_irdy_q     <= 1'b0;
      p_trdy_q     <= 1'b0;
      p_stop_q     <= 1'b0;
      req_lat_q    <= 1'b0;
      viol_ack64_o <= 1'b0;
      viol_ready_o <= 1'b0;
    end else begin
      p_irdy_q <= smp.irdy;
      p_trdy_q <= smp.trdy;
      p_stop_q <= smp.stop;
      if (state == ST_IDLE) req_lat_q <= smp.req64;
      if (ack_bad) viol_ack64_o <= 1'b1;
      if (rdy_bad) viol_ready_o <= 1'b1;
    end
  end

  // R10: acknowledge violation flag is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(viol_ack64_o));

  // R11: ready violation flag is sticky
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(viol_ready_o));

  // R11: flag only rises after an open-transaction sample
  a_r11_rise_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_ready_o) |-> $past(state != ST_IDLE));

endmodule

// File: rtl/pci_term_monitor.sv
module pci_term_monitor
  import pci_term_pkg::*;
#(
  parameter int DEVSEL_WIN = 5,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n,
  input  logic             req64_n,
  input  logic             ack64_n,
  output logic             done,
  output logic [2:0]       outcome,
  output logic [CNT_W-1:0] xfer_count,
  output logic             wide64,
  output logic             viol_ack64,
  output logic             viol_ready
);

  bus_smp_t   smp;
  mon_state_e state;
  outcome_e   term;

  always_comb begin
    smp.frame  = !frame_n;
    smp.irdy   = !irdy_n;
    smp.trdy   = !trdy_n;
    smp.devsel = !devsel_n;
    smp.stop   = !stop_n;
    smp.req64  = !req64_n;
    smp.ack64  = !ack64_n;
  end

  pci_term_classifier #(
    .DEVSEL_WIN(DEVSEL_WIN),
    .CNT_W     (CNT_W)
  ) u_class (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp         (smp),
    .state_o     (state),
    .term_o      (term),
    .done_o      (done),
    .outcome_o   (outcome),
    .xfer_count_o(xfer_count),
    .wide64_o    (wide64)
  );

  pci_term_hs_check u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp         (smp),
    .state       (state),
    .term        (term),
    .viol_ack64_o(viol_ack64),
    .viol_ready_o(viol_ready)
  );

endmodule

// File: tb/pci_term_monitor_tb.sv
`timescale 1ns/1ps
module pci_term_monitor_tb_top;

  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic stop_n = 1'b1, req64_n = 1'b1, ack64_n = 1'b1;
  logic done, wide64, viol_ack64, viol_ready;
  logic [2:0] outcome;
  logic [CNT_W-1:0] xfer_count;

  int checks = 0;
  int failures = 0;

  // reference model state
  int  m_st, m_since, m_ph, m_pend;
  bit  m_dseen, m_rq0, m_aseen, m_pi, m_pt, m_ps;
  bit  e_done, e_w64, e_vack, e_vrdy;
  int  e_out, e_cnt;

  always #2.5 clk = ~clk;

  pci_term_monitor #(.DEVSEL_WIN(5), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
    .req64_n(req64_n), .ack64_n(ack64_n), .done(done), .outcome(outcome),
    .xfer_count(xfer_count), .wide64(wide64), .viol_ack64(viol_ack64),
    .viol_ready(viol_ready)
  );

  function automatic string tag_of(int code);
    case (code)
      1: return "R4";
      2: return "R5";
      3: return "R7";
      4: return "R6";
      5: return "R8";
      6: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", "done", done, e_done);
    chk(tag_of(e_out), "outcome", outcome, e_out);
    chk("R4", "xfer_count", xfer_count, e_cnt);
    chk("R9", "wide64", wide64, e_w64);
    chk("R10", "viol_ack64", viol_ack64, e_vack);
    chk("R11", "viol_ready", viol_ready, e_vrdy);
  endtask

  task automatic model_reset();
    m_st = 0; m_since = 0; m_ph = 0; m_pend = 0;
    m_dseen = 0; m_rq0 = 0; m_aseen = 0; m_pi = 0; m_pt = 0; m_ps = 0;
    e_done = 0; e_w64 = 0; e_vack = 0; e_vrdy = 0; e_out = 0; e_cnt = 0;
  endtask

  task automatic model_step(bit f, bit i, bit t, bit d, bit s, bit rq, bit ak);
    int old_st = m_st;
    int old_pend = m_pend;
    if (ak && (old_st == 0 ? !rq : !m_rq0)) e_vack = 1;
    if (old_st != 0 && old_pend != 6 &&
        ((m_pi && !(m_pt || m_ps) && !i) || (m_pt && !m_pi && !t))) e_vrdy = 1;
    m_pi = i; m_pt = t; m_ps = s;
    e_done = 0;
    if (old_st == 0) begin
      if (f) begin
        m_st = 1; m_since = 0; m_ph = 0; m_dseen = 0; m_rq0 = rq;
        m_aseen = 0; m_pend = 0;
      end
    end else if (old_st == 1) begin
      m_since++;
      if (ak) m_aseen = 1;
      if (!m_dseen && !d && m_since == 5) begin
        m_pend = 6; m_st = 2;
      end else if (s && !d) begin
        m_pend = 5; m_st = 2;
      end else if (s && i) begin
        m_st = 2;
        if (t) begin m_pend = 2; m_ph++; end
        else if (m_ph == 0) m_pend = 4;
        else m_pend = 3;
      end else if (i && t) begin
        m_ph++;
        if (!f) begin m_pend = 1; m_st = 2; end
      end else if (!f && !i) begin
        m_pend = (m_dseen || d) ? 1 : 6; m_st = 2;
      end
      if (d) m_dseen = 1;
    end else begin
      if (ak) m_aseen = 1;
      if (!f && !i) begin
        e_done = 1; e_out = m_pend; e_cnt = m_ph; e_w64 = m_rq0 && m_aseen;
        m_st = 0;
      end
    end
  endtask

  // one bus clock: compare, then drive (arguments: 1 = asserted)
  task automatic cyc(bit f, bit i, bit t, bit d, bit s, bit rq, bit ak);
    @(negedge clk);
    compare_all();
    frame_n = !f; irdy_n = !i; trdy_n = !t; devsel_n = !d;
    stop_n = !s; req64_n = !rq; ack64_n = !ak;
    model_step(f, i, t, d, s, rq, ak);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    frame_n = 1; irdy_n = 1; trdy_n = 1; devsel_n = 1;
    stop_n = 1; req64_n = 1; ack64_n = 1;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    // R1: cleared state after reset
    chk("R1", "reset done", done, 0);
    chk("R1", "reset outcome", outcome, 0);
    chk("R1", "reset count", xfer_count, 0);
    chk("R1", "reset wide64", wide64, 0);
    chk("R1", "reset viol_ack64", viol_ack64, 0);
    chk("R1", "reset viol_ready", viol_ready, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    idle();

    // R4: single-phase 32-bit normal completion
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    idle(); idle();

    // R4 R9: 64-bit burst, slow claim, one wait state, three phases
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(1, 1, 0, 0, 0, 1, 0);
    cyc(1, 1, 0, 1, 0, 1, 1);
    cyc(1, 1, 1, 1, 0, 1, 1);
    cyc(1, 1, 1, 1, 0, 1, 1);
    cyc(0, 1, 1, 1, 0, 0, 1);
    idle(); idle();

    // R3: no claim in the window -> master abort, IRDY# release legal
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    idle(); idle();

    // R3 boundary: claim at the last edge of the window is accepted
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    idle(); idle();

    // R6: stop on first data phase -> retry
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 1, 0, 0);
    cyc(0, 1, 0, 1, 1, 0, 0);
    idle(); idle();

    // R5: disconnect with data after one phase
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 1, 1, 0, 0, 0);
    cyc(1, 1, 1, 1, 1, 0, 0);
    cyc(0, 1, 0, 1, 1, 0, 0);
    idle(); idle();

    // R7: disconnect without data after one phase
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 1, 1, 0, 0, 0);
    cyc(1, 1, 0, 1, 1, 0, 0);
    cyc(0, 1, 0, 1, 1, 0, 0);
    idle(); idle();

    // R8: target abort after claim
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    cyc(1, 1, 0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 1, 0, 0);
    idle();

    // R12: new start in the cycle the previous done pulse is high
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    idle();
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(0, 1, 1, 1, 0, 1, 1);
    idle(); idle();

    // R10: acknowledge without request, then stays set
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 1);
    idle(); idle();
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    idle(); idle();

    // R11: IRDY# withdrawn before completion
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    idle(); idle();

    // R1 again, then R11 via TRDY# withdrawn
    do_reset();
    idle();
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 1, 1, 0, 0, 0);
    cyc(1, 0, 0, 1, 0, 0, 0);
    cyc(0, 1, 1, 1, 0, 0, 0);
    idle(); idle(); idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule